// File: doc/BRIEF.md
# Configurable CRC-16 Coprocessor

This block keeps a 16-bit cyclic redundancy remainder for a contactless framing engine. The engine pulses a start input to load one of four fixed start values, chosen by a 2-bit select. It then presents frame bytes one at a time with a valid strobe. The block folds each accepted byte into the remainder in a single clock, with all eight bit steps unrolled combinationally. A done strobe marks the end of the byte stream.

The remainder is shown as separate upper and lower bytes. A ready flag reports that the stream has ended. An ok flag reports that the remainder is zero. A receiver uses this to check a frame that carries its own CRC: it feeds the payload and the two received CRC bytes, and the remainder then comes to zero. By default the polynomial x^16 + x^12 + x^5 + 1 is applied least-significant bit first in its reflected form. A parameter selects the non-reflected, most-significant-bit-first variant instead.

Top module: `crc16_coproc`

## Requirements
- R1: After reset the remainder is 0x0000, and ready_o and ok_o are low.
- R2: A start_i pulse loads the start value picked by preset_sel_i (00 gives 0x0000, 01 gives 0x6363, 10 gives 0xA671, 11 gives 0xFFFF) and clears ready_o. Both take effect on the next clock.
- R3: With LSB_FIRST=1, each byte with valid_i high updates the remainder in one clock. Each data bit is taken bit 0 first: feedback = rem[0] ^ bit, rem = rem >> 1, and the remainder is XORed with 0x8408 when feedback is 1.
- R4: crc_hi_o shows remainder bits 15..8 and crc_lo_o shows bits 7..0.
- R5: A done_i strobe sets ready_o on the next clock. A byte given with valid_i in that same cycle is still absorbed.
- R6: ok_o is high exactly when ready_o is high and the remainder is zero. With preset 01, feeding a payload followed by its CRC (low byte, then high byte) gives ok_o high.
- R7: While ready_o is high, valid_i bytes are ignored and the remainder holds until the next start_i.
- R8: Cycles with valid_i low leave the remainder unchanged, so gaps in the byte stream do not alter the result.
- R9: When start_i arrives together with valid_i or done_i, start_i wins: the remainder becomes the preset and ready_o stays low.
- R10: With LSB_FIRST=0, data bits are taken bit 7 first: feedback = rem[15] ^ bit, rem = rem << 1, and the remainder is XORed with 0x1021 when feedback is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the selected preset and clear ready |
| preset_sel_i | input | 2 | Start value select |
| data_i | input | 8 | Frame byte |
| valid_i | input | 1 | data_i is to be absorbed this cycle |
| done_i | input | 1 | End of byte stream |
| crc_hi_o | output | 8 | Remainder upper byte |
| crc_lo_o | output | 8 | Remainder lower byte |
| ready_o | output | 1 | Calculation finished |
| ok_o | output | 1 | Finished with zero remainder |

## Verification
Every byte value from 0 to 255 is absorbed as a single-byte frame under each of the four presets. Both bit orders are compared against an arithmetic model. This separates errors in the preset table, in the feedback taps and in the bit order. A frame of 0x00 0x00 with preset 01 is checked against its known result, 0x1EA0. Multi-byte frames with idle gaps show that gaps are harmless and that the done strobe timing is right. The same frames with their CRC appended, once intact and once with one byte corrupted, separate a true ok from a stuck one. Bytes offered after ready, and start given together with valid and done, show the hold and priority rules.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  typedef logic [CRC_W-1:0] crc_t;

  function automatic crc_t preset_value(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16'h0000;
      2'b01:   return 16'h6363;
      2'b10:   return 16'hA671;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic crc_t reflect(input crc_t v);
    crc_t r;
    for (int i = 0; i < int'(CRC_W); i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc16_preset.sv
module crc16_preset
  import crc16_pkg::*;
(
  input  logic [1:0] sel_i,
  output crc_t       value_o
);
  assign value_o = preset_value(sel_i);
endmodule

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
  parameter int unsigned          DATA_W    = 8,
  parameter int unsigned          CRC_W     = 16,
  parameter logic [CRC_W-1:0]     POLY      = 16'h1021,
  parameter bit                   LSB_FIRST = 1'b1
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam logic [CRC_W-1:0] POLY_REFL = crc16_pkg::reflect(POLY);

  logic [CRC_W-1:0] stage [DATA_W+1];
  assign stage[0] = crc_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic fb;
    if (LSB_FIRST) begin : g_lsb
      assign fb           = stage[g][0] ^ data_i[g];
      assign stage[g+1]   = (stage[g] >> 1) ^ (fb ? POLY_REFL : '0);
    end else begin : g_msb
      assign fb           = stage[g][CRC_W-1] ^ data_i[DATA_W-1-g];
      assign stage[g+1]   = (stage[g] << 1) ^ (fb ? POLY : '0);
    end
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  input  logic done_i,
  output logic accept_o,
  output logic ready_o
);
  logic ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ready_q <= 1'b0;
    else if (start_i) ready_q <= 1'b0;
    else if (done_i)  ready_q <= 1'b1;
  end

  // start wins; bytes after done are dropped
  assign accept_o = valid_i & ~ready_q & ~start_i;
  assign ready_o  = ready_q;
endmodule

// File: rtl/crc16_coproc.sv
module crc16_coproc
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY      = 16'h1021,
  parameter bit               LSB_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        preset_sel_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              done_i,
  output logic [CRC_W/2-1:0] crc_hi_o,
  output logic [CRC_W/2-1:0] crc_lo_o,
  output logic              ready_o,
  output logic              ok_o
);
  localparam int unsigned HALF_W = CRC_W / 2;

  crc_t rem_q, preset_w, next_w;
  logic accept_w;

  crc16_preset u_preset (
    .sel_i   (preset_sel_i),
    .value_o (preset_w)
  );

  crc16_byte_step #(
    .DATA_W    (BYTE_W),
    .CRC_W     (CRC_W),
    .POLY      (POLY),
    .LSB_FIRST (LSB_FIRST)
  ) u_step (
    .crc_i  (rem_q),
    .data_i (data_i),
    .crc_o  (next_w)
  );

  crc16_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .valid_i  (valid_i),
    .done_i   (done_i),
    .accept_o (accept_w),
    .ready_o  (ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (start_i)  rem_q <= preset_w;
    else if (accept_w) rem_q <= next_w;
  end

  assign crc_hi_o = rem_q[CRC_W-1 -: HALF_W];
  assign crc_lo_o = rem_q[HALF_W-1:0];
  assign ok_o     = ready_o & ~|rem_q;
endmodule

// File: rtl/crc16_coproc_chk.sv
module crc16_coproc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] preset_sel_i,
  input logic       valid_i,
  input logic       done_i,
  input logic [7:0] crc_hi_o,
  input logic [7:0] crc_lo_o,
  input logic       ready_o,
  input logic       ok_o
);
  // R2
  start_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ({crc_hi_o, crc_lo_o} == crc16_pkg::preset_value($past(preset_sel_i)) && !ready_o));

  // R5
  done_sets_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> ready_o);

  // R7
  frozen_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> (ready_o && $stable({crc_hi_o, crc_lo_o})));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=> $stable({crc_hi_o, crc_lo_o}));

  // R6
  ok_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> ready_o);
endmodule

bind crc16_coproc crc16_coproc_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .preset_sel_i (preset_sel_i),
  .valid_i      (valid_i),
  .done_i       (done_i),
  .crc_hi_o     (crc_hi_o),
  .crc_lo_o     (crc_lo_o),
  .ready_o      (ready_o),
  .ok_o         (ok_o)
);

// File: tb/crc16_coproc_tb_top.sv
`timescale 1ns/1ps
module crc16_coproc_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] preset_sel_i = 2'b00;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       done_i = 1'b0;
  logic [7:0] crc_hi_o, crc_lo_o, m_hi, m_lo;
  logic       ready_o, ok_o, m_ready, m_ok;

  int n_cmp = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  crc16_coproc dut_i (
    .clk_i, .rst_ni, .start_i, .preset_sel_i, .data_i, .valid_i, .done_i,
    .crc_hi_o, .crc_lo_o, .ready_o, .ok_o
  );

  crc16_coproc #(.LSB_FIRST(1'b0)) dut_msb_i (
    .clk_i, .rst_ni, .start_i, .preset_sel_i, .data_i, .valid_i, .done_i,
    .crc_hi_o(m_hi), .crc_lo_o(m_lo), .ready_o(m_ready), .ok_o(m_ok)
  );

  function automatic logic [15:0] pre(input logic [1:0] s);
    logic [15:0] t [4] = '{16'h0000, 16'h6363, 16'hA671, 16'hFFFF};
    return t[s];
  endfunction

  function automatic logic [15:0] ref_lsb(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [15:0] ref_msb(input logic [15:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic start(input logic [1:0] s);
    start_i = 1'b1; preset_sel_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input logic last);
    valid_i = 1'b1; data_i = b; done_i = last;
    @(negedge clk_i);
    valid_i = 1'b0; done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_l, exp_m;
    logic [7:0]  frame [12];
    int          len;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {crc_hi_o, crc_lo_o, 6'd0, ready_o, ok_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {crc_hi_o, crc_lo_o, 6'd0, ready_o, ok_o}, 32'h0);

    // R2 R3 R4 R5 R10: exhaustive single-byte sweep over all presets
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        start(2'(s));
        if (b == 0) chk("R2", {crc_hi_o, crc_lo_o, 15'd0, ready_o}, {pre(2'(s)), 16'h0});
        put(8'(b), 1'b1);
        exp_l = ref_lsb(pre(2'(s)), 8'(b));
        exp_m = ref_msb(pre(2'(s)), 8'(b));
        chk("R3", {crc_hi_o, crc_lo_o}, exp_l);
        chk("R10", {m_hi, m_lo}, exp_m);
        if (b == 7) begin
          chk("R4", crc_hi_o, exp_l[15:8]);
          chk("R5", ready_o, 1'b1);
        end
      end
    end

    // R3 known vector: preset 01, bytes 00 00 -> 0x1EA0
    start(2'b01); put(8'h00, 1'b0); put(8'h00, 1'b1);
    chk("R3", {crc_hi_o, crc_lo_o}, 16'h1EA0);
    chk("R4", crc_lo_o, 8'hA0);

    // R5 R6 R8: multi-byte frames with gaps, then appended CRC
    for (int f = 0; f < 6; f++) begin
      len = 1 + (f * 3) % 10;
      exp_l = pre(2'b01);
      for (int i = 0; i < len; i++) begin
        frame[i] = 8'((f * 37 + i * 91 + 5) ^ (i << 3));
        exp_l = ref_lsb(exp_l, frame[i]);
      end
      start(2'b01);
      for (int i = 0; i < len; i++) begin
        put(frame[i], 1'b0);
        if (i % 2 == 1) @(negedge clk_i); // R8 gap
      end
      chk("R5", ready_o, 1'b0);
      done_i = 1'b1; @(negedge clk_i); done_i = 1'b0;
      chk("R5", ready_o, 1'b1);
      chk("R8", {crc_hi_o, crc_lo_o}, exp_l);
      // R6 intact frame plus crc
      start(2'b01);
      for (int i = 0; i < len; i++) put(frame[i], 1'b0);
      put(exp_l[7:0], 1'b0); put(exp_l[15:8], 1'b1);
      chk("R6", {15'd0, ok_o}, 16'h1);
      // R6 corrupted
      start(2'b01);
      for (int i = 0; i < len; i++) put(i == 0 ? frame[i] ^ 8'h10 : frame[i], 1'b0);
      put(exp_l[7:0], 1'b0); put(exp_l[15:8], 1'b1);
      chk("R6", {15'd0, ok_o}, 16'h0);
    end

    // R7 bytes after ready ignored
    start(2'b11); put(8'h5A, 1'b1);
    exp_l = ref_lsb(16'hFFFF, 8'h5A);
    put(8'hC3, 1'b0); put(8'h11, 1'b1);
    chk("R7", {crc_hi_o, crc_lo_o, 15'd0, ready_o}, {exp_l, 16'h1});

    // R9 start wins over valid and done
    start_i = 1'b1; preset_sel_i = 2'b10; valid_i = 1'b1; data_i = 8'hFF; done_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; valid_i = 1'b0; done_i = 1'b0;
    chk("R9", {crc_hi_o, crc_lo_o, 15'd0, ready_o}, {16'hA671, 16'h0});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule